// File: doc/BRIEF.md
# Windowed Pixel Output Port with Rate Pacing

The block takes a stream of pixels up to 12 bits wide, one per cycle at most, and cuts a 10-bit window out of each one. It then sends the windowed words out at a slower, programmable pace. A small first-in first-out store absorbs the difference between the incoming burst rate and the outgoing pace. Everything runs on one clock. The slower output rate is modelled as a one-cycle tick that fires every N cycles, where N comes from a 6-bit divide field and is clamped to the range 2 to 8.

A port enable gates the whole path. While the enable is low, the store is emptied, the pacing counter is held at zero, the output valid stays low and incoming pixels are ignored. A pixel that arrives while the store is already full is lost. The loss raises a sticky overflow flag, and only dropping the enable clears it. This lets software detect a pace setting that is too slow for the incoming pixel rate.

Top module: `vpo_port`

## Requirements
- R1: After reset, `vid_valid` is 0, `vid_data` is 0 and `overflow` is 0.
- R2: The window select picks the forwarded bits as follows: 0 gives pixel bits [11:2], 1 gives [10:1], 2 gives [9:0], and any other value gives [9:0]. The select is applied when the pixel is accepted.
- R3: The effective divide N is the divide field clamped to the range 2 to 8. Ticks fire every N cycles. The first tick comes on the N-th rising edge that sees the enable high, so the first word leaves on that edge when the store holds data.
- R4: Words leave in the order they were accepted, at most one per tick, and only while the store is non-empty.
- R5: The store holds 8 words. A valid pixel that arrives while the store holds 8 words is dropped, and `overflow` reads 1 from the next cycle. The full test uses the occupancy before that cycle's read.
- R6: `overflow` stays at 1 while the enable remains high, and goes to 0 on the first clock edge that sees the enable low.
- R7: While the enable is low, no pixel is accepted, `vid_valid` is 0, and any words held in the store are discarded.
- R8: `vid_valid` is high for exactly one cycle per word, and only right after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Port enable; low flushes the store and clears overflow |
| win_sel | input | 3 | Window select for the 10-bit slice |
| div_sel | input | 6 | Output pace divide field, clamped to 2..8 |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | 12 | Input pixel |
| vid_valid | output | 1 | Output word strobe |
| vid_data | output | 10 | Output word |
| overflow | output | 1 | Sticky flag for dropped pixels |

## Verification
The assertions check on every cycle that the store occupancy stays within bounds, that ticks never fire on back-to-back cycles, and that `vid_valid` follows a tick. They also check that a drop raises `overflow`, that the flag holds while enabled, and that the output goes quiet once the enable falls. Only the bench scenarios can show the rest. These are the exact bit slice for each select value, the clamped spacing between output words, and the arrival cycle of the first word. They also cover which pixel of a burst is the first one lost, and the discarding of stored words when the port is disabled and then re-enabled.

// File: rtl/vpo_pkg.sv
package vpo_pkg;
  localparam int PIX_W      = 12;
  localparam int VID_W      = 10;
  localparam int SEL_W      = 3;
  localparam int DIV_W      = 6;
  localparam int DIV_MIN    = 2;
  localparam int DIV_MAX    = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int SPAN       = PIX_W - VID_W;
  localparam int CNT_W      = $clog2(DIV_MAX + 1);

  // Slice VID_W bits: select s keeps bits shifted down by SPAN-s; out of range keeps the low bits.
  function automatic logic [VID_W-1:0] pick_window(input logic [PIX_W-1:0] d,
                                                   input logic [SEL_W-1:0] s);
    int sh;
    logic [PIX_W-1:0] t;
    sh = (int'(s) <= SPAN) ? (SPAN - int'(s)) : 0;
    t  = d >> sh;
    return t[VID_W-1:0];
  endfunction

  // Effective pace divide, clamped into [DIV_MIN, DIV_MAX].
  function automatic logic [CNT_W-1:0] clamp_div(input logic [DIV_W-1:0] f);
    if (int'(f) < DIV_MIN) return CNT_W'(DIV_MIN);
    if (int'(f) > DIV_MAX) return CNT_W'(DIV_MAX);
    return CNT_W'(f);
  endfunction
endpackage

// File: rtl/vpo_window.sv
module vpo_window
  import vpo_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [SEL_W-1:0] sel,
  output logic [VID_W-1:0] win
);
  always_comb win = pick_window(pix, sel);
endmodule

// File: rtl/vpo_pace.sv
module vpo_pace
  import vpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [CNT_W-1:0] div_n;
  logic [CNT_W-1:0] cnt;

  always_comb div_n = clamp_div(div_sel);
  // ">=" keeps the pace sane if the divide shrinks mid-count
  always_comb tick  = en && (cnt >= (div_n - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  // R3: a divide of at least 2 never gives adjacent ticks
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R3: the counter stays inside the largest period
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < DIV_MAX);
endmodule

// File: rtl/vpo_fifo.sv
module vpo_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          wr_take, rd_take;

  always_comb begin
    full    = (count == CW'(DEPTH));
    empty   = (count == '0);
    wr_take = push && !full;
    rd_take = pop && !empty;
    rdata   = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_take) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + AW'(1);
      if (rd_take) rp <= (int'(rp) == DEPTH-1) ? '0 : rp + AW'(1);
      count <= count + CW'(wr_take) - CW'(rd_take);
    end
  end

  // R5: occupancy never exceeds the depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  // R5: a push against a full store without a read leaves it full
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush && !rd_take) |=> full);
  // R7: a flush empties the store
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/vpo_port.sv
module vpo_port
  import vpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] win_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             vid_valid,
  output logic [VID_W-1:0] vid_data,
  output logic             overflow
);
  logic [VID_W-1:0] win;
  logic [VID_W-1:0] head;
  logic             tick, full, empty;
  logic             push_req, drop, pop;

  vpo_window u_win (.pix(pix_data), .sel(win_sel), .win(win));

  vpo_pace u_pace (.clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .tick(tick));

  always_comb begin
    push_req = en && pix_valid;
    drop     = push_req && full;
    pop      = tick && !empty;
  end

  vpo_fifo #(.W(VID_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(push_req), .pop(pop),
    .wdata(win), .rdata(head), .full(full), .empty(empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_valid <= 1'b0;
      vid_data  <= '0;
    end else if (!en) begin
      vid_valid <= 1'b0;
    end else begin
      vid_valid <= pop;
      if (pop) vid_data <= head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     overflow <= 1'b0;
    else if (!en)   overflow <= 1'b0;
    else if (drop)  overflow <= 1'b1;
  end

  // R5: a dropped pixel raises the flag
  a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);
  // R6: the flag is sticky while enabled
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && en) |=> overflow);
  // R6: disable clears the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !overflow);
  // R7: nothing leaves while disabled
  a_r7_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vid_valid);
  // R8: an output word always follows a tick
  a_r8_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> $past(tick));
endmodule

// File: tb/vpo_port_test.sv
module vpo_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  win_sel = '0;
  logic [5:0]  div_sel = 6'd2;
  logic        pix_valid = 1'b0;
  logic [11:0] pix_data = '0;
  logic        vid_valid;
  logic [9:0]  vid_data;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_out  = 0;
  string phase = "R1";
  logic [9:0] exp_q[$];
  int t_log[$];

  vpo_port uut (.clk(clk), .rst_n(rst_n), .en(en), .win_sel(win_sel), .div_sel(div_sel),
                .pix_valid(pix_valid), .pix_data(pix_data), .vid_valid(vid_valid),
                .vid_data(vid_data), .overflow(overflow));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] model_win(input logic [11:0] d, input logic [2:0] s);
    case (s)
      3'd0:    return d[11:2];
      3'd1:    return d[10:1];
      default: return d[9:0];
    endcase
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vid_valid) begin
      n_out++;
      t_log.push_back(cyc);
      if (exp_q.size() == 0) chk(1'b0, {phase, " R8 unexpected word"}, vid_data, -1);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(vid_data == e, {phase, " R4 word"}, vid_data, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [11:0] d, input bit keep);
    pix_valid = 1'b1;
    pix_data  = d;
    if (keep) exp_q.push_back(model_win(d, win_sel));
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic rate_case(input logic [5:0] f, input int n);
    int c0;
    en = 1'b0; idle(2);
    div_sel = f; win_sel = 3'd0;
    t_log.delete();
    en = 1'b1; c0 = cyc;
    for (int k = 0; k < 4; k++) send(12'h100 + 12'(k * 37), 1'b1);
    idle(4 * n + 4);
    chk(t_log.size() == 4, "R3 word count", t_log.size(), 4);
    if (t_log.size() == 4) begin
      chk(t_log[0] == c0 + n, "R3 first word cycle", t_log[0] - c0, n);
      for (int k = 1; k < 4; k++)
        chk(t_log[k] - t_log[k-1] == n, "R3 spacing", t_log[k] - t_log[k-1], n);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    chk(vid_valid == 1'b0, "R1 valid", vid_valid, 0);
    chk(vid_data == 10'd0, "R1 data", vid_data, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    rst_n = 1'b1;
    idle(2);

    // R2: window select patterns
    phase = "R2";
    div_sel = 6'd2; en = 1'b1;
    foreach (win_sel_vals[i]) begin
      win_sel = win_sel_vals[i];
      foreach (pats[j]) begin
        send(pats[j], 1'b1);
        idle(3);
      end
    end
    idle(10);
    chk(exp_q.size() == 0, "R2 all words out", exp_q.size(), 0);

    // R3: clamped pacing
    phase = "R3";
    rate_case(6'd0, 2);
    rate_case(6'd5, 5);
    rate_case(6'd63, 8);

    // R5/R6: burst overflow with divide 8; pixels 1..9 kept, 10..12 dropped
    phase = "R5";
    en = 1'b0; idle(2);
    div_sel = 6'd8; win_sel = 3'd1; en = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      if (k == 10) chk(overflow == 1'b0, "R5 no flag before drop", overflow, 0);
      if (k == 11) chk(overflow == 1'b1, "R5 flag after drop", overflow, 1);
      send(12'h0F0 + 12'(k * 5), k <= 9);
    end
    idle(90);
    chk(exp_q.size() == 0, "R5 kept words out", exp_q.size(), 0);
    chk(overflow == 1'b1, "R6 flag sticky", overflow, 1);
    en = 1'b0; idle(1);
    chk(overflow == 1'b0, "R6 flag cleared", overflow, 0);

    // R7: disabled inputs ignored
    phase = "R7";
    c0 = n_out;
    for (int k = 0; k < 4; k++) send(12'h3C3 + 12'(k), 1'b0);
    chk(vid_valid == 1'b0, "R7 quiet while off", vid_valid, 0);
    idle(2);
    div_sel = 6'd2; en = 1'b1;
    idle(30);
    chk(n_out == c0, "R7 ignored pixels", n_out - c0, 0);

    // R7: stored words discarded on disable
    en = 1'b0; idle(2);
    div_sel = 6'd8; en = 1'b1;
    for (int k = 0; k < 3; k++) send(12'h222 + 12'(k), 1'b0);
    en = 1'b0; idle(3);
    en = 1'b1; idle(40);
    chk(n_out == c0, "R7 flushed words", n_out - c0, 0);
    chk(overflow == 1'b0, "R6 no flag", overflow, 0);

    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [2:0]  win_sel_vals [4] = '{3'd0, 3'd1, 3'd2, 3'd5};
  logic [11:0] pats [4] = '{12'hABC, 12'h5A5, 12'hFFF, 12'h001};
endmodule